// File: doc/BRIEF.md
# Relative Jump Decoder and Target Resolver

This block sits behind an instruction fetch path. It reads one instruction byte on each cycle where `byte_vld` is high and recognises the relative control-transfer forms. These are conditional jumps with an 8-bit displacement or with a wide displacement after an escape byte, jump-if-count-zero, and unconditional jumps with a short or wide displacement. It gathers the displacement bytes, lowest byte first.

On the beat that completes an instruction, it resolves the branch. It reads a flags vector for a conditional jump, or the count register at the current address width for jump-if-count-zero. It produces the instruction length, a taken indication and the next fetch address. The next fetch address is the branch target if the branch is taken. Otherwise it is the address just past the instruction. In both cases it is cut down to the effective operand width.

A legacy/long selector and two size codes replace prefix decoding. Long mode forces 64-bit operands. Every instruction length in this brief counts the opcode byte or bytes together with the displacement bytes. A byte that does not start a supported form finishes decoding at once, and the decoder then waits for a fresh opcode.

Top module: `reljmp_resolver`

## Requirements
- R1: A byte 70h..7Fh starts a conditional jump with one displacement byte (length 2). Its low nibble picks the test on `flags_in` (bit0 CF, bit1 PF, bit2 ZF, bit3 SF, bit4 OF). Nibble pairs 0/1 test OF, 2/3 test CF, 4/5 test ZF, 6/7 test CF|ZF, 8/9 test SF, A/B test PF, C/D test SF^OF and E/F test ZF|(SF^OF). The even member of each pair jumps when the test is true and the odd member jumps when it is false.
- R2: The bytes 0Fh then 80h..8Fh form a conditional jump with the same nibble tests as R1. It carries 2 displacement bytes (length 4) when the effective operand size is 16 bits, and 4 bytes (length 6) otherwise.
- R3: E3h takes one displacement byte (length 2). It is taken only when `count_in` is zero over the width chosen by `adsz_in`: 0 means 16 bits, 1 means 32 bits, and 2 or 3 mean 64 bits. `opsz_in` plays no part in this test.
- R4: EBh is always taken with one displacement byte (length 2). E9h is always taken with 2 displacement bytes (length 3) under a 16-bit effective operand size, and with 4 bytes (length 5) otherwise.
- R5: For a taken jump, `next_addr` is `start_addr` plus the length plus the sign-extended displacement. The result is cut to the effective operand width: `opsz_in`=0 gives 16 bits, any other code gives 32 bits, and long mode gives 64 bits. The upper bits are zero.
- R6: For a jump that is not taken, `next_addr` is `start_addr` plus the length, cut as in R5, and `taken` is low.
- R7: With `long_mode` high, the operand size is 64 bits whatever `opsz_in` holds. The wide forms of R2 and R4 then carry 4 displacement bytes sign-extended to 64 bits.
- R8: EAh with `long_mode` high finishes after one byte with `undef_op` high, `unsup` low and `taken` low. With `long_mode` low it is treated as unsupported (R9).
- R9: Any other first byte finishes after 1 byte with `unsup` high. A byte after 0Fh outside 80h..8Fh finishes with length 2 and `unsup` high. In both cases `taken` is low, and the next valid byte is decoded as a new opcode.
- R10: Displacement bytes arrive least significant first. Cycles with `byte_vld` low do not advance decoding.
- R11: `done` is high for exactly the one cycle after the beat that completes an instruction. The result outputs change only together with `done` and hold between completions.
- R12: A synchronous active-low reset clears every output to zero and makes the next valid byte an opcode, even in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | Instruction byte valid this cycle |
| byte_in | input | 8 | Instruction byte |
| start_addr | input | AW | Address of the current instruction's first byte |
| flags_in | input | 5 | {OF,SF,ZF,PF,CF} |
| count_in | input | AW | Count register value |
| long_mode | input | 1 | 64-bit mode select |
| opsz_in | input | 2 | Operand size outside long mode: 0=16, else 32 |
| adsz_in | input | 2 | Address size: 0=16, 1=32, 2/3=64 |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken |
| next_addr | output | AW | Resolved next fetch address |
| ins_len | output | 4 | Instruction length in bytes |
| unsup | output | 1 | Unsupported opcode |
| undef_op | output | 1 | Direct far jump in long mode |

## Verification
The properties assume that `start_addr`, `flags_in`, `count_in`, `long_mode`, `opsz_in` and `adsz_in` do not change from an instruction's first byte until the cycle of its `done` pulse. They also assume that `adsz_in` is never 0 while `long_mode` is high. The stimulus picks the modes and operands before sending any byte of an instruction and keeps them until the result has been checked. It draws the address size only from 32 or 64 bits in long mode. Idle cycles are inserted at random between bytes, and a reset is issued partway through one instruction.

// File: rtl/reljmp_pkg.sv
// Shared encodings for the relative jump resolver.
// Assumes: displacement is at most four bytes; size codes as below.
package reljmp_pkg;
    localparam int MAXD = 4;                 // widest displacement in bytes
    localparam int IW   = $clog2(MAXD);      // byte index width

    localparam logic [1:0] SZ16 = 2'd0;
    localparam logic [1:0] SZ32 = 2'd1;
    localparam logic [1:0] SZ64 = 2'd2;

    // positions within the flags vector
    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_ZF = 2;
    localparam int FL_SF = 3;
    localparam int FL_OF = 4;

    typedef enum logic [1:0] {K_NONE, K_JCC, K_JCXZ, K_JMP} jkind_e;
    typedef enum logic [1:0] {ST_OP, ST_ESC, ST_DISP} dstate_e;
endpackage

// File: rtl/reljmp_cond.sv
// Evaluates a four-bit condition code against the flags vector.
// Assumes: code bits [3:1] choose the test, bit 0 inverts it.
module reljmp_cond
    import reljmp_pkg::*;
(
    input  logic [3:0] cc,
    input  logic [4:0] fl,
    output logic       hit
);
    logic base;
    logic lt;

    // pick the base test, then apply the inversion bit
    always_comb begin
        lt = fl[FL_SF] ^ fl[FL_OF];
        case (cc[3:1])
            3'd0:    base = fl[FL_OF];
            3'd1:    base = fl[FL_CF];
            3'd2:    base = fl[FL_ZF];
            3'd3:    base = fl[FL_CF] | fl[FL_ZF];
            3'd4:    base = fl[FL_SF];
            3'd5:    base = fl[FL_PF];
            3'd6:    base = lt;
            default: base = fl[FL_ZF] | lt;
        endcase
        hit = base ^ cc[0];
    end
endmodule

// File: rtl/reljmp_fsm.sv
// Byte-serial decoder: recognises the opcode, collects the displacement
// lowest byte first and flags the beat that completes the instruction.
// Assumes: long_mode and opsz_in are stable across one instruction.
module reljmp_fsm
    import reljmp_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [7:0]    byte_in,
    input  logic          long_mode,
    input  logic [1:0]    opsz_in,
    output logic          fin,
    output jkind_e        kind,
    output logic [3:0]    cc,
    output logic [AW-1:0] disp_x,
    output logic [3:0]    len,
    output logic          bad_unsup,
    output logic          bad_undef
);
    localparam int DW = 8 * MAXD;

    dstate_e       state_q, state_d;
    jkind_e        kind_q, kind_d;
    logic [3:0]    cc_q, cc_d;
    logic [IW:0]   dlen_q, dlen_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [DW-1:0] disp_q, disp_d, dbytes;
    logic [3:0]    cnt_q;
    logic [IW:0]   wide_len;

    // displacement length of the wide forms under the current sizes
    always_comb begin
        wide_len = (!long_mode && opsz_in == SZ16) ? (IW+1)'(2) : (IW+1)'(MAXD);
    end

    // next-state decode for one valid beat
    always_comb begin
        state_d   = state_q;
        kind_d    = kind_q;
        cc_d      = cc_q;
        dlen_d    = dlen_q;
        idx_d     = idx_q;
        disp_d    = disp_q;
        dbytes    = disp_q;
        fin       = 1'b0;
        bad_unsup = 1'b0;
        bad_undef = 1'b0;
        if (byte_vld) begin
            case (state_q)
                ST_OP: begin
                    idx_d  = '0;
                    disp_d = '0;
                    if (byte_in[7:4] == 4'h7) begin
                        kind_d  = K_JCC;
                        cc_d    = byte_in[3:0];
                        dlen_d  = (IW+1)'(1);
                        state_d = ST_DISP;
                    end else if (byte_in == 8'h0F) begin
                        state_d = ST_ESC;
                    end else if (byte_in == 8'hE3) begin
                        kind_d  = K_JCXZ;
                        dlen_d  = (IW+1)'(1);
                        state_d = ST_DISP;
                    end else if (byte_in == 8'hEB) begin
                        kind_d  = K_JMP;
                        dlen_d  = (IW+1)'(1);
                        state_d = ST_DISP;
                    end else if (byte_in == 8'hE9) begin
                        kind_d  = K_JMP;
                        dlen_d  = wide_len;
                        state_d = ST_DISP;
                    end else if (byte_in == 8'hEA && long_mode) begin
                        fin       = 1'b1;
                        bad_undef = 1'b1;
                    end else begin
                        fin       = 1'b1;
                        bad_unsup = 1'b1;
                    end
                end
                ST_ESC: begin
                    if (byte_in[7:4] == 4'h8) begin
                        kind_d  = K_JCC;
                        cc_d    = byte_in[3:0];
                        dlen_d  = wide_len;
                        state_d = ST_DISP;
                    end else begin
                        fin       = 1'b1;
                        bad_unsup = 1'b1;
                        state_d   = ST_OP;
                    end
                end
                default: begin
                    dbytes[8*idx_q +: 8] = byte_in;
                    disp_d = dbytes;
                    idx_d  = idx_q + IW'(1);
                    if ((IW+1)'(idx_q) + (IW+1)'(1) == dlen_d) begin
                        fin     = 1'b1;
                        state_d = ST_OP;
                    end
                end
            endcase
        end
    end

    // sign-extend the gathered displacement by its length
    always_comb begin
        case (dlen_q)
            (IW+1)'(1): disp_x = {{(AW-8){dbytes[7]}}, dbytes[7:0]};
            (IW+1)'(2): disp_x = {{(AW-16){dbytes[15]}}, dbytes[15:0]};
            default:    disp_x = {{(AW-DW){dbytes[DW-1]}}, dbytes};
        endcase
    end

    assign kind = kind_q;
    assign cc   = cc_q;
    assign len  = cnt_q + 4'd1;

    // decoder state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OP;
            kind_q  <= K_NONE;
            cc_q    <= '0;
            dlen_q  <= '0;
            idx_q   <= '0;
            disp_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            cc_q    <= cc_d;
            dlen_q  <= dlen_d;
            idx_q   <= idx_d;
            disp_q  <= disp_d;
            if (byte_vld) cnt_q <= fin ? 4'd0 : cnt_q + 4'd1;
        end
    end
endmodule

// File: rtl/reljmp_target.sv
// Forms the next fetch address and cuts it to the operand width.
// Assumes: AW is at least 32; osz already reflects long mode.
module reljmp_target
    import reljmp_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [AW-1:0] base,
    input  logic [3:0]    len,
    input  logic [AW-1:0] disp,
    input  logic          take,
    input  logic [1:0]    osz,
    output logic [AW-1:0] dest
);
    logic [AW-1:0] seq;
    logic [AW-1:0] raw;

    // sequential address, optional displacement, then truncation
    always_comb begin
        seq = base + AW'(len);
        raw = take ? seq + disp : seq;
        case (osz)
            SZ16:    dest = {{(AW-16){1'b0}}, raw[15:0]};
            SZ32:    dest = {{(AW-32){1'b0}}, raw[31:0]};
            default: dest = raw;
        endcase
    end
endmodule

// File: rtl/reljmp_resolver.sv
// Top: byte-serial decode and resolution of relative jumps.
// Assumes: address, flags, count and size inputs are held from an
// instruction's first byte to its done pulse.
module reljmp_resolver
    import reljmp_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [7:0]    byte_in,
    input  logic [AW-1:0] start_addr,
    input  logic [4:0]    flags_in,
    input  logic [AW-1:0] count_in,
    input  logic          long_mode,
    input  logic [1:0]    opsz_in,
    input  logic [1:0]    adsz_in,
    output logic          done,
    output logic          taken,
    output logic [AW-1:0] next_addr,
    output logic [3:0]    ins_len,
    output logic          unsup,
    output logic          undef_op
);
    logic          fin, bad_unsup, bad_undef, hit, cnt_zero, take_c;
    jkind_e        kind;
    logic [3:0]    cc, len;
    logic [AW-1:0] disp_x, dest;
    logic [1:0]    osz_eff;

    reljmp_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .long_mode(long_mode), .opsz_in(opsz_in), .fin(fin), .kind(kind),
        .cc(cc), .disp_x(disp_x), .len(len), .bad_unsup(bad_unsup),
        .bad_undef(bad_undef)
    );

    reljmp_cond u_cond (.cc(cc), .fl(flags_in), .hit(hit));

    // effective operand size and count-zero test at the address width
    always_comb begin
        osz_eff = long_mode ? SZ64 : ((opsz_in == SZ16) ? SZ16 : SZ32);
        case (adsz_in)
            SZ16:    cnt_zero = (count_in[15:0] == '0);
            SZ32:    cnt_zero = (count_in[31:0] == '0);
            default: cnt_zero = (count_in == '0);
        endcase
        case (kind)
            K_JCC:   take_c = hit;
            K_JCXZ:  take_c = cnt_zero;
            K_JMP:   take_c = 1'b1;
            default: take_c = 1'b0;
        endcase
        if (bad_unsup || bad_undef) take_c = 1'b0;
    end

    reljmp_target #(.AW(AW)) u_tgt (
        .base(start_addr), .len(len), .disp(disp_x), .take(take_c),
        .osz(osz_eff), .dest(dest)
    );

    // result registers: pulse done, hold results between completions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            taken     <= 1'b0;
            next_addr <= '0;
            ins_len   <= '0;
            unsup     <= 1'b0;
            undef_op  <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                taken     <= take_c;
                next_addr <= dest;
                ins_len   <= len;
                unsup     <= bad_unsup;
                undef_op  <= bad_undef;
            end
        end
    end
endmodule

// File: rtl/reljmp_resolver_chk.sv
// Checker for reljmp_resolver, attached through bind.
// Assumes: size inputs are held until the done pulse.
module reljmp_resolver_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_vld,
    input logic          long_mode,
    input logic [1:0]    opsz_in,
    input logic          done,
    input logic          taken,
    input logic [AW-1:0] next_addr,
    input logic [3:0]    ins_len,
    input logic          unsup,
    input logic          undef_op
);
    // R11: a completion follows a valid beat
    p_done_after_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_vld));

    // R11: results hold while no completion is reported
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({taken, next_addr, ins_len, unsup, undef_op}));

    // R5: 16-bit operand size leaves the upper address bits clear
    p_trunc16_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(!long_mode && opsz_in == 2'd0)) |-> next_addr[AW-1:16] == '0);

    // R5: 32-bit operand size leaves the upper address bits clear
    p_trunc32_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(!long_mode && opsz_in != 2'd0)) |-> next_addr[AW-1:32] == '0);

    // R8: undefined far jump only in long mode, one byte, never taken
    p_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && undef_op) |-> ($past(long_mode) && ins_len == 4'd1 && !taken && !unsup));

    // R9: unsupported opcode is short and never taken
    p_unsup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && unsup) |-> ((ins_len == 4'd1 || ins_len == 4'd2) && !taken && !undef_op));

    // R10: a supported jump spans two to six bytes
    p_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !unsup && !undef_op) |-> (ins_len >= 4'd2 && ins_len <= 4'd6));
endmodule

bind reljmp_resolver reljmp_resolver_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .long_mode(long_mode),
    .opsz_in(opsz_in), .done(done), .taken(taken), .next_addr(next_addr),
    .ins_len(ins_len), .unsup(unsup), .undef_op(undef_op)
);

// File: tb/reljmp_resolver_tb.sv
module reljmp_resolver_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [63:0] start_addr = '0;
    logic [4:0]  flags_in = '0;
    logic [63:0] count_in = '0;
    logic        long_mode = 1'b0;
    logic [1:0]  opsz_in = '0;
    logic [1:0]  adsz_in = '0;
    logic        done, taken, unsup, undef_op;
    logic [63:0] next_addr;
    logic [3:0]  ins_len;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reljmp_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .start_addr(start_addr), .flags_in(flags_in), .count_in(count_in),
        .long_mode(long_mode), .opsz_in(opsz_in), .adsz_in(adsz_in),
        .done(done), .taken(taken), .next_addr(next_addr), .ins_len(ins_len),
        .unsup(unsup), .undef_op(undef_op)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // condition table written out case by case
    function automatic logic cond_ok(input logic [3:0] c, input logic [4:0] f);
        logic cf, pf, zf, sf, of_;
        cf = f[0]; pf = f[1]; zf = f[2]; sf = f[3]; of_ = f[4];
        case (c)
            4'h0: return of_ == 1'b1;
            4'h1: return of_ == 1'b0;
            4'h2: return cf == 1'b1;
            4'h3: return cf == 1'b0;
            4'h4: return zf == 1'b1;
            4'h5: return zf == 1'b0;
            4'h6: return cf || zf;
            4'h7: return !cf && !zf;
            4'h8: return sf == 1'b1;
            4'h9: return sf == 1'b0;
            4'hA: return pf == 1'b1;
            4'hB: return pf == 1'b0;
            4'hC: return sf != of_;
            4'hD: return sf == of_;
            4'hE: return zf || (sf != of_);
            default: return !zf && (sf == of_);
        endcase
    endfunction

    task automatic send_byte(input logic [7:0] b, input bit gaps);
        if (gaps) begin
            int g = $urandom % 3;
            for (int k = 0; k < g; k++) begin
                @(negedge clk);
                byte_vld = 1'b0;
            end
        end
        @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
    endtask

    // form: 0 jcc short, 1 jcc near, 2 count-zero, 3 jmp short, 4 jmp near,
    //       5 EA, 6 unsupported byte, 7 escape then unsupported byte
    task automatic do_insn(input int form, input logic [3:0] cc, input logic [31:0] dv, input bit gaps);
        logic [7:0]  bq [6];
        int          n = 0;
        int          dn = 0;
        bit          w16;
        logic [63:0] dx, mask, enext;
        logic        etk = 1'b0, eun = 1'b0, eud = 1'b0;
        int          elen;
        string       rq;
        w16 = !long_mode && opsz_in == 2'd0;
        case (form)
            0: begin bq[0] = 8'h70 | {4'h0, cc}; n = 1; dn = 1; etk = cond_ok(cc, flags_in); rq = "R1"; end
            1: begin bq[0] = 8'h0F; bq[1] = 8'h80 | {4'h0, cc}; n = 2; dn = w16 ? 2 : 4; etk = cond_ok(cc, flags_in); rq = "R2"; end
            2: begin
                bq[0] = 8'hE3; n = 1; dn = 1; rq = "R3";
                etk = (adsz_in == 2'd0) ? (count_in[15:0] == 0) :
                      (adsz_in == 2'd1) ? (count_in[31:0] == 0) : (count_in == 0);
               end
            3: begin bq[0] = 8'hEB; n = 1; dn = 1; etk = 1'b1; rq = "R4"; end
            4: begin bq[0] = 8'hE9; n = 1; dn = w16 ? 2 : 4; etk = 1'b1; rq = "R4"; end
            5: begin bq[0] = 8'hEA; n = 1; eud = long_mode; eun = !long_mode; rq = long_mode ? "R8" : "R9"; end
            6: begin bq[0] = 8'hC3; n = 1; eun = 1'b1; rq = "R9"; end
            default: begin bq[0] = 8'h0F; bq[1] = 8'h0B; n = 2; eun = 1'b1; rq = "R9"; end
        endcase
        for (int i = 0; i < dn; i++) bq[n + i] = dv[8*i +: 8];
        elen = n + dn;
        case (dn)
            1: dx = {{56{dv[7]}}, dv[7:0]};
            2: dx = {{48{dv[15]}}, dv[15:0]};
            4: dx = {{32{dv[31]}}, dv};
            default: dx = '0;
        endcase
        mask  = long_mode ? 64'hFFFF_FFFF_FFFF_FFFF : (w16 ? 64'hFFFF : 64'hFFFF_FFFF);
        enext = (start_addr + 64'(elen) + (etk ? dx : 64'd0)) & mask;
        for (int i = 0; i < elen; i++) send_byte(bq[i], gaps);
        @(negedge clk);
        byte_vld = 1'b0;
        chk("R11", "done pulse", {63'd0, done}, 64'd1);
        chk(rq, "taken", {63'd0, taken}, {63'd0, etk});
        chk(etk ? "R5" : "R6", "next_addr", next_addr, enext);
        chk("R10", "length", {60'd0, ins_len}, 64'(elen));
        chk("R9", "unsup", {63'd0, unsup}, {63'd0, eun});
        chk("R8", "undef_op", {63'd0, undef_op}, {63'd0, eud});
        @(negedge clk);
        chk("R11", "done low", {63'd0, done}, 64'd0);
        chk("R11", "held next_addr", next_addr, enext);
    endtask

    task automatic set_mode(input logic lm, input logic [1:0] os, input logic [1:0] as_, input logic [63:0] st);
        long_mode = lm; opsz_in = os; adsz_in = as_; start_addr = st;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "reset done", {63'd0, done}, 64'd0);
        chk("R12", "reset next_addr", next_addr, 64'd0);
        chk("R12", "reset len", {60'd0, ins_len}, 64'd0);
        rst_n = 1'b1;

        // R5: 16-bit wrap of a short forward jump
        set_mode(1'b0, 2'd0, 2'd0, 64'hFFFE);
        do_insn(3, 4'h0, 32'h05, 1'b0);
        // R5: 32-bit wide backward jump wrapping below zero
        set_mode(1'b0, 2'd1, 2'd1, 64'h1000);
        do_insn(4, 4'h0, 32'hFFFF_E000, 1'b1);
        // R4: wide jump under 16-bit operand size uses two bytes
        set_mode(1'b0, 2'd0, 2'd0, 64'h1234);
        do_insn(4, 4'h0, 32'h0000_8000, 1'b0);
        // R7: long mode, escape-form jump with negative 32-bit displacement
        set_mode(1'b1, 2'd0, 2'd2, 64'h0000_7FFF_0000_0010);
        flags_in = 5'b00100;
        do_insn(1, 4'h4, 32'h8000_0000, 1'b0);
        // R7: long mode ignores a 16-bit operand code for E9
        do_insn(4, 4'h0, 32'hFFFF_FFF0, 1'b1);
        // R3: count width follows address size
        set_mode(1'b0, 2'd1, 2'd0, 64'h400);
        count_in = 64'h1_0000;
        do_insn(2, 4'h0, 32'h10, 1'b0);
        adsz_in = 2'd1;
        do_insn(2, 4'h0, 32'h10, 1'b0);
        // R8 / R9: far direct jump by mode, unsupported bytes
        set_mode(1'b1, 2'd1, 2'd2, 64'h8000);
        do_insn(5, 4'h0, 32'h0, 1'b0);
        set_mode(1'b0, 2'd1, 2'd1, 64'h8000);
        do_insn(5, 4'h0, 32'h0, 1'b0);
        do_insn(7, 4'h0, 32'h0, 1'b0);
        do_insn(6, 4'h0, 32'h0, 1'b0);
        // R1: every condition under several flag patterns
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 4; f++) begin
                flags_in = 5'($urandom);
                do_insn(0, 4'(c), 32'($urandom), 1'b0);
            end
        end
        // R12: reset in the middle of an escape-form instruction
        send_byte(8'h0F, 1'b0);
        @(negedge clk);
        byte_vld = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12", "mid reset next_addr", next_addr, 64'd0);
        rst_n = 1'b1;
        set_mode(1'b0, 2'd1, 2'd1, 64'h2000);
        do_insn(3, 4'h0, 32'h02, 1'b0);

        // random mix
        for (int t = 0; t < 500; t++) begin
            logic lm;
            lm = 1'($urandom);
            if (lm) set_mode(1'b1, 2'($urandom), 2'd1 + 2'($urandom % 2), {$urandom, $urandom});
            else    set_mode(1'b0, 2'($urandom % 2), 2'($urandom % 2), {$urandom, $urandom});
            flags_in = 5'($urandom);
            case ($urandom % 4)
                0: count_in = 64'd0;
                1: count_in = 64'h1_0000_0000;
                2: count_in = 64'h1_0000;
                default: count_in = {$urandom, $urandom};
            endcase
            do_insn(int'($urandom % 8), 4'($urandom), $urandom, 1'b1);
        end
        finish_up();
    end
endmodule